// File: doc/BRIEF.md
# Stall Guard for Hall-Sensed Motor Drive

This block decides whether a hall-sensed motor is stalled, and while it is stalled it makes the power stage run in bursts. A slow timebase tick drives it. Between hall edges it counts those ticks. When the motor is commanded to run and the count reaches a tick limit, the motor counts as stalled. The tick limit is small when the sensed rotation runs against the commanded direction and large when the rotation agrees with it.

Once stalled, the block alternates drive windows and rest windows. A rest window is always six times as long as a drive window. During a rest window the drive enable is low. Two things end the stalled state: a hall edge that arrives sooner than the tick limit after the previous edge, or a stop command. A stop command also resets all counting. The next run command starts the count again from zero.

Analog comparators upstream produce the run and stop levels. A hall decoder upstream produces the edge strobe and the mismatch flag. The drive enable gates the commutation outputs downstream.

Top module: `stall_guard`

## Requirements
- R1: After reset, `drive_en` is 1 and `lock_active` is 0, and the block stays idle until `run_req` is seen.
- R2: While idle, tick pulses without any hall edge never set `lock_active`.
- R3: Once running with `dir_mismatch` = 0, `lock_active` rises on the clock after the FWD_LIMIT-th tick that arrives with no hall edge since the start or since the last edge. It does not rise after one tick fewer.
- R4: With `dir_mismatch` = 1, the limit used in R3 is REV_LIMIT ticks instead.
- R5: A hall edge sets the tick-gap count back to zero. If hall edges keep arriving within the limit, the block never locks.
- R6: While locked, `drive_en` stays 1 for DRIVE_TICKS ticks and then 0 for 6×DRIVE_TICKS ticks, and this repeats. `drive_en` is never 0 unless `lock_active` is 1.
- R7: While locked, a hall edge that arrives fewer than the active limit ticks after the previous edge clears `lock_active` and sets `drive_en` to 1 on the next clock.
- R8: `stop_req` sends the block idle from any state on the next clock, with `lock_active` = 0 and `drive_en` = 1.
- R9: When `stop_req` and `run_req` are both high, `stop_req` wins.
- R10: After a stop, a new run request starts the gap count from zero, so a full limit of ticks is again needed to lock.
- R11: While locked, a hall edge that arrives at or beyond the limit since the previous edge does not release the lock. It only restarts the gap count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_req | input | 1 | Speed command is above the start threshold |
| stop_req | input | 1 | Speed command is at or below the off threshold |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| hall_edge | input | 1 | One-cycle strobe for any hall transition |
| dir_mismatch | input | 1 | Sensed rotation opposes the commanded direction |
| drive_en | output | 1 | Power stage may switch; low during stall rest windows |
| lock_active | output | 1 | Stall detected, burst drive in force |

## Verification
The assertions take `tick` and `hall_edge` to be single-cycle strobes. They also assume that `stop_req` and `run_req` come from thresholds that do not toggle every clock. On those terms, every change of `drive_en` or `lock_active` must trace back to a tick, an edge or a stop in the cycle before. The directed stimulus walks each mode boundary one tick at a time. The mixed phase draws strobes at random but still drives each one for a single clock. It also keeps stop pulses rare, so that long stall windows can play out between them.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_WATCH = 2'd1,
        SG_BURST = 2'd2,
        SG_REST  = 2'd3
    } sg_state_t;

    typedef struct packed {
        sg_state_t state;
        logic      drive;
        logic      locked;
    } sg_regs_t;

endpackage

// File: rtl/stall_gap_timer.sv
// Counts timebase ticks since the last hall edge, saturating at all ones.
module stall_gap_timer #(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [GAP_W-1:0] gap
);
    localparam logic [GAP_W-1:0] GAP_TOP = '1;

    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (clear) begin
            gap_d = '0;
        end else if (tick && (gap_q != GAP_TOP)) begin
            gap_d = gap_q + GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign gap = gap_q;
endmodule

// File: rtl/stall_duty_timer.sv
// Phase counter for the burst and rest windows; wraps at a supplied terminal value.
module stall_duty_timer #(
    parameter int unsigned PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic [PH_W-1:0] last,
    output logic            wrap
);
    logic [PH_W-1:0] ph_d, ph_q;
    logic            at_end;

    always_comb begin
        at_end = (ph_q == last);
        ph_d   = ph_q;
        if (clear) begin
            ph_d = '0;
        end else if (tick) begin
            ph_d = at_end ? '0 : ph_q + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign wrap = tick && !clear && at_end;
endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_guard_pkg::*;
#(
    parameter int unsigned FWD_LIMIT   = 100,
    parameter int unsigned REV_LIMIT   = 20,
    parameter int unsigned DRIVE_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic stop_req,
    input  logic tick,
    input  logic hall_edge,
    input  logic dir_mismatch,
    output logic drive_en,
    output logic lock_active
);
    localparam int unsigned REST_RATIO = 6;
    localparam int unsigned REST_TICKS = REST_RATIO * DRIVE_TICKS;
    localparam int unsigned MAX_LIMIT  = (FWD_LIMIT > REV_LIMIT) ? FWD_LIMIT : REV_LIMIT;
    localparam int unsigned GAP_W      = $clog2(MAX_LIMIT + 1) + 1;
    localparam int unsigned PH_W       = $clog2(REST_TICKS + 1);
    localparam logic [GAP_W:0]  FWD_LIM_W  = (GAP_W+1)'(FWD_LIMIT);
    localparam logic [GAP_W:0]  REV_LIM_W  = (GAP_W+1)'(REV_LIMIT);
    localparam logic [PH_W-1:0] BURST_LAST = PH_W'(DRIVE_TICKS - 1);
    localparam logic [PH_W-1:0] REST_LAST  = PH_W'(REST_TICKS - 1);

    sg_regs_t r_d, r_q;

    logic [GAP_W-1:0] gap;
    logic [GAP_W:0]   gap_ext, gap_inc, limit;
    logic             in_lock, gap_clear, ph_clear, ph_wrap;
    logic             expire, quick_edge;
    logic [PH_W-1:0]  ph_last;

    always_comb begin
        in_lock    = (r_q.state == SG_BURST) || (r_q.state == SG_REST);
        limit      = dir_mismatch ? REV_LIM_W : FWD_LIM_W;
        gap_ext    = {1'b0, gap};
        gap_inc    = gap_ext + (GAP_W+1)'(1);
        expire     = tick && !hall_edge && (gap_inc >= limit);
        quick_edge = hall_edge && (gap_ext < limit);
        gap_clear  = stop_req || (r_q.state == SG_IDLE) || hall_edge;
        ph_clear   = !in_lock;
        ph_last    = (r_q.state == SG_BURST) ? BURST_LAST : REST_LAST;
    end

    stall_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (gap_clear),
        .tick  (tick),
        .gap   (gap)
    );

    stall_duty_timer #(.PH_W(PH_W)) u_duty (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ph_clear),
        .tick  (tick),
        .last  (ph_last),
        .wrap  (ph_wrap)
    );

    always_comb begin
        r_d = r_q;
        if (stop_req) begin
            r_d.state = SG_IDLE;
        end else begin
            unique case (r_q.state)
                SG_IDLE:  if (run_req) r_d.state = SG_WATCH;
                SG_WATCH: if (expire)  r_d.state = SG_BURST;
                SG_BURST: begin
                    if (quick_edge)   r_d.state = SG_WATCH;
                    else if (ph_wrap) r_d.state = SG_REST;
                end
                SG_REST: begin
                    if (quick_edge)   r_d.state = SG_WATCH;
                    else if (ph_wrap) r_d.state = SG_BURST;
                end
                default: r_d.state = SG_IDLE;
            endcase
        end
        r_d.drive  = (r_d.state != SG_REST);
        r_d.locked = (r_d.state == SG_BURST) || (r_d.state == SG_REST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= SG_IDLE;
            r_q.drive  <= 1'b1;
            r_q.locked <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_en    = r_q.drive;
    assign lock_active = r_q.locked;
endmodule

// File: rtl/stall_guard_checks.sv
module stall_guard_checks (
    input logic clk,
    input logic rst_n,
    input logic run_req,
    input logic stop_req,
    input logic tick,
    input logic hall_edge,
    input logic dir_mismatch,
    input logic drive_en,
    input logic lock_active
);
    // R6: a rest window only exists inside a stall
    a_r6_rest_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> lock_active);

    // R6: entering a rest window only from a burst window
    a_r6_rest_from_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> $past(lock_active) && $past(tick));

    // R3, R4: a stall is declared only on a tick with no edge and no stop
    a_r3_lock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_active) |-> $past(tick) && !$past(hall_edge) && !$past(stop_req));

    // R7, R8: leaving a stall needs a hall edge or a stop
    a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_active) |-> $past(hall_edge) || $past(stop_req));

    // R8, R9: a stop always leaves the block unlocked and driving
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !lock_active && drive_en);

    // R6: drive enable switches only on a tick, an edge or a stop
    a_r6_drive_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_en) |-> $past(tick) || $past(hall_edge) || $past(stop_req));
endmodule

bind stall_guard stall_guard_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_req      (run_req),
    .stop_req     (stop_req),
    .tick         (tick),
    .hall_edge    (hall_edge),
    .dir_mismatch (dir_mismatch),
    .drive_en     (drive_en),
    .lock_active  (lock_active)
);

// File: tb/sim_stall_guard.sv
`timescale 1ns/1ps
module sim_stall_guard;
    localparam int FWD = 6;
    localparam int REV = 2;
    localparam int ON  = 3;
    localparam int OFF = 6 * ON;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0, stop_req = 1'b0, tick = 1'b0, hall_edge = 1'b0, dir_mismatch = 1'b0;
    logic drive_en, lock_active;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stall_guard #(.FWD_LIMIT(FWD), .REV_LIMIT(REV), .DRIVE_TICKS(ON)) u0 (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .stop_req(stop_req),
        .tick(tick), .hall_edge(hall_edge), .dir_mismatch(dir_mismatch),
        .drive_en(drive_en), .lock_active(lock_active)
    );

    // Behavioural reference: mode 0 idle, 1 watching, 2 locked-driving, 3 locked-resting
    int m_mode = 0;
    int m_gap  = 0;
    int m_ph   = 0;

    always @(posedge clk) begin
        int lim;
        if (!rst_n) begin
            m_mode = 0; m_gap = 0; m_ph = 0;
        end else begin
            lim = dir_mismatch ? REV : FWD;
            if (stop_req) begin
                m_mode = 0; m_gap = 0; m_ph = 0;
            end else if (m_mode == 0) begin
                m_gap = 0;
                if (run_req) m_mode = 1;
            end else if (m_mode == 1) begin
                m_ph = 0;
                if (hall_edge) m_gap = 0;
                else if (tick) begin
                    m_gap++;
                    if (m_gap >= lim) m_mode = 2;
                end
            end else begin
                if (hall_edge && m_gap < lim) begin
                    m_mode = 1; m_gap = 0; m_ph = 0;
                end else begin
                    if (hall_edge) m_gap = 0;
                    else if (tick) m_gap++;
                    if (tick) begin
                        m_ph++;
                        if (m_ph == ((m_mode == 2) ? ON : OFF)) begin
                            m_ph = 0;
                            m_mode = (m_mode == 2) ? 3 : 2;
                        end
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_compare();
        check("R3 lock_active vs model", lock_active, (m_mode >= 2));
        check("R6 drive_en vs model", drive_en, (m_mode != 3));
    endtask

    task automatic step(input logic r, input logic s, input logic t, input logic e, input logic m);
        run_req = r; stop_req = s; tick = t; hall_edge = e; dir_mismatch = m;
        @(posedge clk);
        @(negedge clk);
        model_compare();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 drive_en in reset", drive_en, 1'b1);
        check("R1 lock_active in reset", lock_active, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 drive_en after reset", drive_en, 1'b1);
        check("R1 lock_active after reset", lock_active, 1'b0);

        // R2: idle ignores ticks
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0);
        check("R2 no lock while idle", lock_active, 1'b0);

        // Start running
        step(1, 0, 0, 0, 0);
        // R5: edges every third tick keep it unlocked
        for (int i = 0; i < 30; i++) step(1, 0, 1, (i % 3) == 2, 0);
        check("R5 frequent edges prevent lock", lock_active, 1'b0);
        step(1, 0, 0, 1, 0);

        // R3: FWD ticks without edges
        for (int i = 0; i < FWD - 1; i++) step(1, 0, 1, 0, 0);
        check("R3 one tick short of limit", lock_active, 1'b0);
        step(1, 0, 1, 0, 0);
        check("R3 lock at limit", lock_active, 1'b1);
        check("R6 burst starts driving", drive_en, 1'b1);

        // R6: burst then rest windows
        for (int i = 0; i < ON - 1; i++) step(1, 0, 1, 0, 0);
        check("R6 still in burst", drive_en, 1'b1);
        step(1, 0, 1, 0, 0);
        check("R6 rest window begins", drive_en, 1'b0);
        for (int i = 0; i < OFF - 1; i++) step(1, 0, 1, 0, 0);
        check("R6 rest window lasts six bursts", drive_en, 1'b0);
        step(1, 0, 1, 0, 0);
        check("R6 burst resumes", drive_en, 1'b1);
        check("R6 still locked", lock_active, 1'b1);

        // R11: slow edge does not release
        step(1, 0, 0, 1, 0);
        check("R11 slow edge keeps lock", lock_active, 1'b1);
        // R7: quick edge releases
        step(1, 0, 1, 0, 0);
        step(1, 0, 0, 1, 0);
        check("R7 quick edge releases lock", lock_active, 1'b0);
        check("R7 drive restored", drive_en, 1'b1);

        // R4: mismatch uses the short limit
        step(1, 0, 1, 0, 1);
        check("R4 one tick short of reverse limit", lock_active, 1'b0);
        step(1, 0, 1, 0, 1);
        check("R4 lock at reverse limit", lock_active, 1'b1);
        for (int i = 0; i < ON; i++) step(1, 0, 1, 0, 1);
        check("R6 rest under mismatch", drive_en, 1'b0);

        // R8: stop during rest
        step(0, 1, 0, 0, 1);
        check("R8 stop clears lock", lock_active, 1'b0);
        check("R8 stop restores drive", drive_en, 1'b1);

        // R9: stop dominates run
        for (int i = 0; i < 10; i++) step(1, 1, 1, 0, 0);
        check("R9 stop wins over run", lock_active, 1'b0);

        // R10: fresh count after restart
        step(1, 0, 1, 0, 0);
        for (int i = 0; i < FWD - 1; i++) step(1, 0, 1, 0, 0);
        check("R10 fresh count not yet at limit", lock_active, 1'b0);
        step(1, 0, 1, 0, 0);
        check("R10 lock after full fresh count", lock_active, 1'b1);

        // Mixed stimulus against the model
        for (int i = 0; i < 4000; i++) begin
            logic s, r, t, e, m;
            s = ($urandom_range(0, 299) == 0);
            r = ($urandom_range(0, 3) != 0);
            t = ($urandom_range(0, 1) == 0);
            e = ((i / 200) % 2 == 0) ? ($urandom_range(0, 3) == 0)
                                     : ($urandom_range(0, 40) == 0);
            m = ((i / 500) % 2 == 1);
            step(r, s, t, e, m);
        end

        done = 1'b1;
        finish_run();
    end
endmodule